// File: doc/BRIEF.md
# Hyperbolic-Tangent Activation Lookup

This block is the nonlinear activation stage for the hidden layer of a small fixed-point neural network. It accepts one signed fixed-point argument per cycle, qualified by a valid strobe. It returns the hyperbolic tangent of that argument one clock later, also qualified by a valid strobe. The result is not computed from an approximation formula. It is read from a table of tangent values sampled every 0.01 over the interval from -2.0 to +2.0, so all of the accuracy comes from the stored entries.

The argument is rounded to the nearest 0.01 step to form a table index. Arguments whose magnitude reaches 2.0 or more use the end entries. The table is filled at elaboration from the sample step and the format parameters, and each entry is the integer value of its fixed-point code. Only the non-negative half of the curve is stored. Negative arguments read the entry for their magnitude and negate it, so the transfer curve is exactly odd.

Top module: `tansig_lut`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` equals the `in_valid` of the previous clock cycle, so each accepted argument produces exactly one result, one cycle later.
- R3: `out_data` changes only in the cycle after `in_valid` was high. While no argument is accepted it holds its last value, whatever is on `in_data`.
- R4: `in_data` and `out_data` are 10-bit two's complement codes with 8 fraction bits. A code c stands for c/256, so -512 is -2.0, 256 is +1.0 and 511 is about 1.996.
- R5: The table step is k = floor((|c|·100 + 128) / 256), which is |c|/2.56 rounded to the nearest integer, with exact halves rounded away from zero. The sign of the argument is applied afterwards. For example, code 32 (0.125) uses step 13.
- R6: The entry for step k is round(256·tanh(k/100)), rounded to the nearest code. For example, input 269 (about 1.05) gives output 200 (about 0.781).
- R7: The transfer is odd. Input 0 gives 0, and input -c gives the exact negation of the result for +c.
- R8: A magnitude whose step would exceed 200 uses step 200. Both end codes therefore land on the tanh(2.0) entry: -512 gives -247 and 511 gives +247.
- R9: Every result lies within -256 to +256, that is, within ±1.0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Argument on `in_data` is accepted this cycle |
| in_data | input | 10 | Signed argument, 8 fraction bits |
| out_valid | output | 1 | `out_data` carries a new result |
| out_data | output | 10 | Signed tanh result, 8 fraction bits |

## Verification
A back-to-back sweep applies all 1024 argument codes. It shows whether the index rounding, the half-step ties and the end clamping pick the right entry for every code, and whether the table contents agree with a tanh computed independently in floating point. The sweep results are then compared in mirrored pairs, which exposes any break in odd symmetry or a sign bit applied on the wrong side of the table. Random traffic with gaps in the valid strobe and junk on the idle data bus separates correct one-cycle latency and hold behaviour from an output that follows the bus. Directed single arguments cover 0, the worked value 269, the tie code 32 and the two end codes.

// File: rtl/tansig_lut.sv
`timescale 1ns/1ps
module tansig_lut #(
  parameter int W     = 10,
  parameter int FRAC  = 8,
  parameter int STEPS = 100,
  parameter int RANGE = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int HALF = RANGE * STEPS;
  localparam int IW   = $clog2(HALF + 1);
  localparam int Q    = 28;
  localparam logic signed [W-1:0] UNIT = W'(1 << FRAC);

  function automatic int tanh_mag(input int k);
    longint one, s, p, sum, t, scale;
    one = 64'sd1 <<< Q;
    t   = 64'sd1 <<< 60;
    sum = t;
    for (int n = 1; n <= 10; n++) begin
      t   = (t * 2) / (longint'(STEPS) * n);
      sum = sum + t;
    end
    s = (sum + (64'sd1 <<< 31)) >>> 32;
    p = one;
    for (int b = 0; b < 16; b++) begin
      if (k[b]) p = (p * s + (one >>> 1)) >>> Q;
      if ((k >> (b + 1)) != 0) s = (s * s + (one >>> 1)) >>> Q;
    end
    scale = 64'sd1 <<< FRAC;
    return int'((2 * scale * (p - one) + (p + one)) / (2 * (p + one)));
  endfunction

  logic [W-1:0] rom [HALF+1];

  for (genvar g = 0; g <= HALF; g++) begin : g_rom
    localparam logic [W-1:0] ENTRY = W'(tanh_mag(g));
    assign rom[g] = ENTRY;
  end

  logic         neg;
  logic [W-1:0] mag;
  logic [31:0]  scaled;
  logic [31:0]  step;
  logic [IW-1:0] idx;
  logic [W-1:0] entry;
  logic [W-1:0] result;

  assign neg    = in_data[W-1];
  assign mag    = neg ? -in_data : in_data;
  assign scaled = 32'(mag) * 32'(STEPS) + 32'(1 << (FRAC - 1));
  assign step   = scaled >> FRAC;
  assign idx    = (step > 32'(HALF)) ? IW'(HALF) : step[IW-1:0];
  assign entry  = rom[idx];
  assign result = neg ? -entry : entry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= result;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  // R7
  zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data == '0) |=> out_data == '0);
  // R7
  pos_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_data[W-1]) |=> !out_data[W-1]);
  // R7
  neg_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data[W-1]) |=> (out_data[W-1] || out_data == '0));
  // R9
  out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(out_data) <= UNIT) && ($signed(out_data) >= -UNIT));
endmodule

// File: tb/tansig_lut_test.sv
`timescale 1ns/1ps
module tansig_lut_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [9:0] in_data = '0;
  logic       out_valid;
  logic [9:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int sweep_res [1024];

  tansig_lut uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #2.5 clk = ~clk;

  function automatic int ref_tansig(input int c);
    int m, k, r;
    real e, v;
    m = (c < 0) ? -c : c;
    k = (m * 100 + 128) / 256;
    if (k > 200) k = 200;
    e = $exp(2.0 * k / 100.0);
    v = 256.0 * (e - 1.0) / (e + 1.0);
    r = $rtoi($floor(v + 0.5));
    return (c < 0) ? -r : r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int outs();
    return int'($signed(out_data));
  endfunction

  task automatic send_one(input int c, input string tag);
    int held;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 10'(c);
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 10'($urandom);
    chk({tag, " R2 valid"}, int'(out_valid), 1);
    chk(tag, outs(), ref_tansig(c));
    held = outs();
    @(negedge clk);
    in_data = 10'($urandom);
    chk("R2 valid drops", int'(out_valid), 0);
    chk("R3 hold idle", outs(), held);
  endtask

  initial begin
    int dummy;
    int prev_valid, hold_val, pend_val;
    dummy = int'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    in_valid = 1'b1;
    in_data  = 10'd100;
    @(negedge clk);
    chk("R1 reset valid", int'(out_valid), 0);
    chk("R1 reset data", outs(), 0);
    in_valid = 1'b0;
    rst_n = 1'b1;

    send_one(269, "R6 worked value");
    send_one(0, "R7 zero");
    send_one(-512, "R8 low end");
    send_one(511, "R8 high end");
    send_one(32, "R5 tie positive");
    send_one(-32, "R5 tie negative");
    send_one(256, "R4 one");
    send_one(-1, "R7 tiny negative");

    for (int i = -512; i <= 512; i++) begin
      @(negedge clk);
      if (i > -512) begin
        chk("R5 sweep valid", int'(out_valid), 1);
        chk("R5 R6 sweep", outs(), ref_tansig(i - 1));
        sweep_res[i - 1 + 512] = outs();
        checks++;
        if (outs() > 256 || outs() < -256) begin
          errors++;
          $display("FAIL R9 range: actual %0d expected within -256..256", outs());
        end
      end
      in_valid = (i < 512);
      in_data  = 10'(i);
    end
    for (int c = 1; c <= 511; c++)
      chk("R7 symmetry", sweep_res[512 - c], -sweep_res[512 + c]);

    prev_valid = 0;
    hold_val = outs();
    pend_val = hold_val;
    for (int n = 0; n < 3000; n++) begin
      int v, c;
      @(negedge clk);
      chk("R2 random valid", int'(out_valid), prev_valid);
      if (prev_valid != 0) hold_val = pend_val;
      chk("R3 random data", outs(), hold_val);
      v = int'($urandom % 2);
      c = int'($urandom % 1024) - 512;
      in_valid = v[0];
      in_data  = 10'(c);
      prev_valid = v;
      if (v != 0) pend_val = ref_tansig(c);
    end
    @(negedge clk);
    in_valid = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule